// File: doc/BRIEF.md
# Excitation Propagation Micro-Engine

This block is a single processing element that carries out one excitation propagation step when it is started. It reads a block of scalars and arrays from its own local memory, accumulates excitation from a set of shared-memory words, limits the result to a ceiling and scales it into a set of output signals through a signed divide. It then removes those signals from the local excitation and publishes the excitation and each signal to shared memory. The whole step is a fixed program: there is no instruction fetch. The only thing that varies is the data and counts held in local memory.

The engine drives a single-port local memory with one-cycle synchronous read latency. It reaches shared memory through a request/grant port. An optional quiet mode ends the step early, before any shared-memory write, when the limited excitation falls below a floor value. Division runs in a bit-serial divider inside the block. Each signal therefore costs about two data-width cycles.

Top module: `exc_engine`

## Requirements
- R1: After reset, done, err, sm_req and lm_we are all 0 and the engine waits for start.
- R2: Local memory with K entries per array is laid out as: permeabilities at 0..K-1, source addresses at K..2K-1, destination addresses at 2K..3K-1, signals at 3K..4K-1. Scalars follow at 4K+0..7 in this order: excitation, ceiling, floor, scale divisor, input count, output count, external-input address, publish address.
- R3: The gathered excitation equals the stored excitation plus the shared word at the external-input address, plus the shared word at each source address i for i below the input count. All of this is 32-bit wrapping two's-complement arithmetic.
- R4: After gathering, the excitation is limited to at most the ceiling, using a signed comparison.
- R5: For each i below the output count, signal i is the 64-bit signed product of the limited excitation and permeability i, divided by the scale divisor and truncated toward zero. The low 32 bits are written to local signal slot i.
- R6: The final excitation is the limited excitation minus the sum of all new signals. It is written back to the local excitation slot. It then goes to shared memory at the publish address first, followed by each signal i at destination address i in increasing i.
- R7: Both counts are read as unsigned. A count of K or more acts as K-1, and a count of zero skips its loop entirely.
- R8: When a division is due and the scale divisor is zero, that signal is 0 and err is set. Once set, err stays 1 until reset. No division means no error.
- R9: With gate_en at 1 and the limited excitation below the floor (signed), the step makes no shared-memory write. It stores the limited excitation in the local excitation slot, leaves all signal slots untouched and finishes.
- R10: done is high for exactly one cycle, after the last shared-memory write grant or after the early exit. A start pulse while a step is running has no effect.
- R11: sm_req, sm_we, sm_addr and sm_wdata stay unchanged from the cycle a request is raised until sm_gnt. Read data is taken in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one propagation step (ignored while busy) |
| gate_en | input | 1 | Enable early exit below the floor |
| done | output | 1 | One-cycle step-complete pulse |
| err | output | 1 | Sticky zero-divisor flag |
| lm_addr | output | LM_AW | Local memory word address |
| lm_we | output | 1 | Local memory write enable |
| lm_wdata | output | DW | Local memory write data |
| lm_rdata | input | DW | Local memory read data, one cycle after address |
| sm_req | output | 1 | Shared memory access request |
| sm_we | output | 1 | Shared memory write (1) or read (0) |
| sm_addr | output | DW | Shared memory word address |
| sm_wdata | output | DW | Shared memory write data |
| sm_gnt | input | 1 | Shared memory grant |
| sm_rdata | input | DW | Shared memory read data, valid with grant |

## Verification
The bench sweeps both counts from zero through values past K, including an all-ones count. An engine that treated counts as signed, failed to saturate, or ran one loop pass on a zero count would show the wrong number of shared writes or a corrupted sentinel in a signal slot. Scale divisors of both signs and several magnitudes catch a divider that floors instead of truncating, or that loses the sign of the 64-bit product. A ceiling below the gathered sum, including a negative one, exposes an unsigned or missing limit. The quiet mode is tried above and below the floor, where a faulty engine would either publish anyway or drop a step it should run. A zero divisor with and without outputs, a start pulse during a step, and grant latencies of zero to two cycles probe the sticky flag, start handling and request hold.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // Scalar slot offsets above the four arrays (R2)
  localparam int SC_EXC  = 0;
  localparam int SC_MAX  = 1;
  localparam int SC_MIN  = 2;
  localparam int SC_FAC  = 3;
  localparam int SC_NIN  = 4;
  localparam int SC_NOUT = 5;
  localparam int SC_EXT  = 6;
  localparam int SC_PUB  = 7;
  localparam int NSCAL   = 8;

  typedef enum logic [4:0] {
    S_IDLE, S_LOAD, S_EXT, S_SRC_RD, S_SRC_CAP, S_SRC_SM, S_CLAMP,
    S_PER_RD, S_PER_CAP, S_DIV, S_SIG_WR, S_DRAIN, S_EXC_WB, S_PUB,
    S_DST_RD, S_DST_CAP, S_SIG_CAP, S_DST_SM, S_EXIT_WB, S_DONE
  } eng_state_t;

endpackage

// File: rtl/exc_limit.sv
module exc_limit #(
  parameter int DW = 32,
  parameter int K  = 8,
  parameter int IW = $clog2(K) + 1
) (
  input  logic [DW-1:0]         exc_in,
  input  logic [DW-1:0]         exc_ceil,
  input  logic [1:0][DW-1:0]    cnt_raw,
  output logic [DW-1:0]         exc_out,
  output logic [1:0][IW-1:0]    cnt_sat
);

  assign exc_out = ($signed(exc_in) > $signed(exc_ceil)) ? exc_ceil : exc_in;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    assign cnt_sat[g] = (cnt_raw[g] >= DW'(K)) ? IW'(K - 1) : cnt_raw[g][IW-1:0];
  end

endmodule

// File: rtl/exc_divider.sv
module exc_divider #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   quot
);

  localparam int NW = 2 * DW;
  localparam int CW = $clog2(NW) + 1;

  logic          busy_q, busy_d, done_q, done_d, neg_q, neg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rem_q, rem_d, dvs_q, dvs_d;
  logic [NW-1:0] num_q, num_d;
  logic [NW-1:0] nd_mag;
  logic [DW-1:0] dv_mag;
  logic [DW:0]   rem_sh;
  logic          fits;

  assign nd_mag = dividend[NW-1] ? (~dividend + NW'(1)) : dividend;
  assign dv_mag = divisor[DW-1]  ? (~divisor + DW'(1))  : divisor;
  assign rem_sh = {rem_q, num_q[NW-1]};
  assign fits   = rem_sh >= {1'b0, dvs_q};

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    neg_d  = neg_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    num_d  = num_q;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      neg_d  = dividend[NW-1] ^ divisor[DW-1];
      cnt_d  = CW'(NW);
      rem_d  = '0;
      dvs_d  = dv_mag;
      num_d  = nd_mag;
    end else if (busy_q) begin
      rem_d = fits ? DW'(rem_sh - {1'b0, dvs_q}) : rem_sh[DW-1:0];
      num_d = {num_q[NW-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      num_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      neg_q  <= neg_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      num_q  <= num_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quot = neg_q ? (~num_q[DW-1:0] + DW'(1)) : num_q[DW-1:0];

  // R5
  div_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/exc_engine.sv
module exc_engine #(
  parameter int DW    = 32,
  parameter int K     = 8,
  parameter int LM_AW = $clog2(5 * K)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gate_en,
  output logic             done,
  output logic             err,
  output logic [LM_AW-1:0] lm_addr,
  output logic             lm_we,
  output logic [DW-1:0]    lm_wdata,
  input  logic [DW-1:0]    lm_rdata,
  output logic             sm_req,
  output logic             sm_we,
  output logic [DW-1:0]    sm_addr,
  output logic [DW-1:0]    sm_wdata,
  input  logic             sm_gnt,
  input  logic [DW-1:0]    sm_rdata
);
  import exc_pkg::*;

  localparam int IW        = $clog2(K) + 1;
  localparam int LW        = $clog2(NSCAL) + 1;
  localparam int PER_BASE  = 0;
  localparam int SRC_BASE  = K;
  localparam int DST_BASE  = 2 * K;
  localparam int SIG_BASE  = 3 * K;
  localparam int SCAL_BASE = 4 * K;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  eng_state_t    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [LW-1:0] ld_q, ld_d;
  logic [DW-1:0] scal_q [NSCAL];
  logic [DW-1:0] exc_q, exc_d, acc_q, acc_d, tmp_q, tmp_d, sig_q, sig_d;
  logic          err_q, err_d;
  logic          scal_en;
  logic [DW-1:0] scal_wd;

  logic [DW-1:0]      exc_clip;
  logic [1:0][IW-1:0] cnt_sat;
  logic [IW-1:0]      n_in_s, n_out_s;
  logic [IW-1:0]      idx_nx;

  logic            div_go, div_busy, div_done;
  logic [DW-1:0]   div_quot;
  logic [2*DW-1:0] prod;

  exc_limit #(.DW(DW), .K(K), .IW(IW)) u_limit (
    .exc_in   (exc_q),
    .exc_ceil (scal_q[SC_MAX]),
    .cnt_raw  ({scal_q[SC_NOUT], scal_q[SC_NIN]}),
    .exc_out  (exc_clip),
    .cnt_sat  (cnt_sat)
  );
  assign n_in_s  = cnt_sat[0];
  assign n_out_s = cnt_sat[1];
  assign idx_nx  = idx_q + IW'(1);

  assign prod = {{DW{exc_q[DW-1]}}, exc_q} * {{DW{lm_rdata[DW-1]}}, lm_rdata};

  exc_divider #(.DW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .go       (div_go),
    .dividend (prod),
    .divisor  (scal_q[SC_FAC]),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_quot)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    ld_d     = ld_q;
    exc_d    = exc_q;
    acc_d    = acc_q;
    tmp_d    = tmp_q;
    sig_d    = sig_q;
    err_d    = err_q;
    scal_en  = 1'b0;
    scal_wd  = lm_rdata;
    div_go   = 1'b0;
    done     = 1'b0;
    lm_addr  = '0;
    lm_we    = 1'b0;
    lm_wdata = '0;
    sm_req   = 1'b0;
    sm_we    = 1'b0;
    sm_addr  = '0;
    sm_wdata = '0;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d = S_LOAD;
        ld_d    = '0;
      end
      S_LOAD: begin
        lm_addr = LM_AW'(SCAL_BASE) + LM_AW'(ld_q);
        scal_en = (ld_q != '0);
        ld_d    = ld_q + LW'(1);
        if (ld_q == LW'(NSCAL)) begin
          exc_d   = scal_q[SC_EXC];
          state_d = S_EXT;
        end
      end
      S_EXT: begin
        sm_req  = 1'b1;
        sm_addr = scal_q[SC_EXT];
        if (sm_gnt) begin
          exc_d   = exc_q + sm_rdata;
          idx_d   = '0;
          state_d = (n_in_s == '0) ? S_CLAMP : S_SRC_RD;
        end
      end
      S_SRC_RD: begin
        lm_addr = LM_AW'(SRC_BASE) + LM_AW'(idx_q);
        state_d = S_SRC_CAP;
      end
      S_SRC_CAP: begin
        tmp_d   = lm_rdata;
        state_d = S_SRC_SM;
      end
      S_SRC_SM: begin
        sm_req  = 1'b1;
        sm_addr = tmp_q;
        if (sm_gnt) begin
          exc_d   = exc_q + sm_rdata;
          idx_d   = idx_nx;
          state_d = (idx_nx == n_in_s) ? S_CLAMP : S_SRC_RD;
        end
      end
      S_CLAMP: begin
        exc_d = exc_clip;
        acc_d = '0;
        idx_d = '0;
        if (gate_en && ($signed(exc_clip) < $signed(scal_q[SC_MIN])))
          state_d = S_EXIT_WB;
        else
          state_d = (n_out_s == '0) ? S_DRAIN : S_PER_RD;
      end
      S_PER_RD: begin
        lm_addr = LM_AW'(PER_BASE) + LM_AW'(idx_q);
        state_d = S_PER_CAP;
      end
      S_PER_CAP: begin
        if (scal_q[SC_FAC] == '0) begin
          sig_d   = '0;
          err_d   = 1'b1;
          state_d = S_SIG_WR;
        end else begin
          div_go  = 1'b1;
          state_d = S_DIV;
        end
      end
      S_DIV: if (div_done) begin
        sig_d   = div_quot;
        state_d = S_SIG_WR;
      end
      S_SIG_WR: begin
        lm_we    = 1'b1;
        lm_addr  = LM_AW'(SIG_BASE) + LM_AW'(idx_q);
        lm_wdata = sig_q;
        acc_d    = acc_q + sig_q;
        if (idx_nx == n_out_s) begin
          idx_d   = '0;
          state_d = S_DRAIN;
        end else begin
          idx_d   = idx_nx;
          state_d = S_PER_RD;
        end
      end
      S_DRAIN: begin
        exc_d   = exc_q - acc_q;
        state_d = S_EXC_WB;
      end
      S_EXC_WB: begin
        lm_we    = 1'b1;
        lm_addr  = LM_AW'(SCAL_BASE + SC_EXC);
        lm_wdata = exc_q;
        state_d  = S_PUB;
      end
      S_PUB: begin
        sm_req   = 1'b1;
        sm_we    = 1'b1;
        sm_addr  = scal_q[SC_PUB];
        sm_wdata = exc_q;
        if (sm_gnt) begin
          idx_d   = '0;
          state_d = (n_out_s == '0) ? S_DONE : S_DST_RD;
        end
      end
      S_DST_RD: begin
        lm_addr = LM_AW'(DST_BASE) + LM_AW'(idx_q);
        state_d = S_DST_CAP;
      end
      S_DST_CAP: begin
        tmp_d   = lm_rdata;
        lm_addr = LM_AW'(SIG_BASE) + LM_AW'(idx_q);
        state_d = S_SIG_CAP;
      end
      S_SIG_CAP: begin
        sig_d   = lm_rdata;
        state_d = S_DST_SM;
      end
      S_DST_SM: begin
        sm_req   = 1'b1;
        sm_we    = 1'b1;
        sm_addr  = tmp_q;
        sm_wdata = sig_q;
        if (sm_gnt) begin
          idx_d   = idx_nx;
          state_d = (idx_nx == n_out_s) ? S_DONE : S_DST_RD;
        end
      end
      S_EXIT_WB: begin
        lm_we    = 1'b1;
        lm_addr  = LM_AW'(SCAL_BASE + SC_EXC);
        lm_wdata = exc_q;
        state_d  = S_DONE;
      end
      S_DONE: begin
        done    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ld_q    <= '0;
      exc_q   <= '0;
      acc_q   <= '0;
      tmp_q   <= '0;
      sig_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ld_q    <= ld_d;
      exc_q   <= exc_d;
      acc_q   <= acc_d;
      tmp_q   <= tmp_d;
      sig_q   <= sig_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int s = 0; s < NSCAL; s++) scal_q[s] <= '0;
    end else if (scal_en) begin
      scal_q[ld_q - LW'(1)] <= scal_wd;
    end
  end

  assign err = err_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);

  // R4
  ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == S_CLAMP) |=> ($signed(exc_q) <= $signed(scal_q[SC_MAX])));

  // R7
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == S_SRC_RD || state_q == S_PER_RD || state_q == S_DST_RD) |-> (idx_q < IW'(K)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    err |=> err);

  // R11
  sm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sm_req && !sm_gnt) |=> (sm_req && $stable(sm_addr) && $stable(sm_we) && $stable(sm_wdata)));

  // R5
  div_launch_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    div_go |-> !div_busy);

endmodule

// File: tb/exc_engine_tb.sv
`timescale 1ns/1ps
module exc_engine_tb;
  localparam int DW    = 32;
  localparam int K     = 8;
  localparam int NLM   = 5 * K;
  localparam int LM_AW = $clog2(NLM);
  localparam int SMD   = 64;
  localparam int LOGN  = 1024;

  logic clk, rst_n, start, gate_en, done, err;
  logic [LM_AW-1:0] lm_addr;
  logic lm_we;
  logic [DW-1:0] lm_wdata, lm_rdata;
  logic sm_req, sm_we, sm_gnt;
  logic [DW-1:0] sm_addr, sm_wdata, sm_rdata;

  exc_engine #(.DW(DW), .K(K), .LM_AW(LM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_en(gate_en),
    .done(done), .err(err),
    .lm_addr(lm_addr), .lm_we(lm_we), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata),
    .sm_req(sm_req), .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata),
    .sm_gnt(sm_gnt), .sm_rdata(sm_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [DW-1:0] lm [NLM];
  logic [DW-1:0] sm [SMD];
  logic [DW-1:0] wl_addr [LOGN];
  logic [DW-1:0] wl_data [LOGN];
  int wl_n, done_cnt, proto_err, wcnt, lat;
  int n_chk, n_fail;
  int unsigned seed;
  logic p_wait, p_we;
  logic [DW-1:0] p_addr, p_wd;

  always @(posedge clk) begin
    if (lm_we) lm[lm_addr] <= lm_wdata;
    lm_rdata <= lm[lm_addr];
  end

  assign sm_gnt   = sm_req && (wcnt >= lat);
  assign sm_rdata = sm[sm_addr[5:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= 0; wl_n <= 0; done_cnt <= 0; proto_err <= 0;
      p_wait <= 1'b0; p_we <= 1'b0; p_addr <= '0; p_wd <= '0;
    end else begin
      wcnt <= (sm_req && !sm_gnt) ? wcnt + 1 : 0;
      if (sm_req && sm_gnt && sm_we) begin
        sm[sm_addr[5:0]] <= sm_wdata;
        if (wl_n < LOGN) begin
          wl_addr[wl_n] <= sm_addr;
          wl_data[wl_n] <= sm_wdata;
        end
        wl_n <= wl_n + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
      if (p_wait && (!sm_req || sm_addr != p_addr || sm_we != p_we || sm_wdata != p_wd))
        proto_err <= proto_err + 1;
      p_wait <= sm_req && !sm_gnt;
      p_addr <= sm_addr; p_we <= sm_we; p_wd <= sm_wdata;
    end
  end

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return lo + int'((seed >> 8) % (hi - lo + 1));
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, $signed(act), $signed(exp));
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  bit err_exp;

  task automatic run_case(string tag, int n_in, int n_out, int fac, int exc0,
                          int ceil_v, int floor_v, bit gate, bit extra_start);
    int per [K];
    int dst [K];
    int src [K];
    int exp_sig [K];
    int ex_a [K+1];
    int ex_d [K+1];
    int ex_n, nin_s, nout_s, e, base, dc0, waited;
    bit exited;
    int unsigned ui, uo;
    longint p;
    for (int i = 0; i < SMD; i++) sm[i] = DW'(rnd(-20, 20));
    for (int i = 0; i < K; i++) begin
      per[i] = rnd(-10, 10);
      src[i] = rnd(0, 15);
      dst[i] = 32 + i;
      lm[i]         = DW'(per[i]);
      lm[K + i]     = DW'(src[i]);
      lm[2 * K + i] = DW'(dst[i]);
      lm[3 * K + i] = 32'hBEEF0000 + DW'(i);
    end
    lm[4*K+0] = DW'(exc0);   lm[4*K+1] = DW'(ceil_v); lm[4*K+2] = DW'(floor_v);
    lm[4*K+3] = DW'(fac);    lm[4*K+4] = DW'(n_in);   lm[4*K+5] = DW'(n_out);
    lm[4*K+6] = 32'd50;      lm[4*K+7] = 32'd60;
    // Expected behaviour from the requirements
    ui = n_in; uo = n_out;
    nin_s  = (ui >= K) ? K - 1 : n_in;
    nout_s = (uo >= K) ? K - 1 : n_out;
    e = exc0 + int'($signed(sm[50]));
    for (int i = 0; i < nin_s; i++) e += int'($signed(sm[src[i]]));
    if (e > ceil_v) e = ceil_v;
    exited = gate && (e < floor_v);
    ex_n = 0;
    if (!exited) begin
      for (int i = 0; i < nout_s; i++) begin
        if (fac == 0) begin
          exp_sig[i] = 0; err_exp = 1'b1;
        end else begin
          p = longint'(e) * longint'(per[i]);
          exp_sig[i] = int'(p / longint'(fac));
        end
      end
      for (int i = 0; i < nout_s; i++) e -= exp_sig[i];
      ex_a[0] = 60; ex_d[0] = e; ex_n = 1;
      for (int i = 0; i < nout_s; i++) begin
        ex_a[ex_n] = dst[i]; ex_d[ex_n] = exp_sig[i]; ex_n++;
      end
    end
    base = wl_n; dc0 = done_cnt;
    gate_en = gate;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk); waited++;
    end
    if (!done) chk(tag, "R10 done timeout", 32'd0, 32'd1);
    @(negedge clk);
    chk(tag, "R10 done one cycle", DW'(done), 32'd0);
    repeat (6) @(negedge clk);
    chk(tag, "R10 done count", DW'(done_cnt - dc0), 32'd1);
    chk(tag, exited ? "R9 shared write count" : "R6 shared write count", DW'(wl_n - base), DW'(ex_n));
    for (int i = 0; i < ex_n; i++) begin
      if (base + i < LOGN && base + i < wl_n) begin
        chk(tag, "R6 write address", wl_addr[base + i], DW'(ex_a[i]));
        chk(tag, "R6 write data", wl_data[base + i], DW'(ex_d[i]));
      end
    end
    for (int i = 0; i < K; i++) begin
      if (!exited && i < nout_s) chk(tag, "R5 R2 signal slot", lm[3*K+i], DW'(exp_sig[i]));
      else                       chk(tag, "R7 R9 untouched signal slot", lm[3*K+i], 32'hBEEF0000 + DW'(i));
    end
    chk(tag, "R3 R4 R6 excitation slot", lm[4*K+0], DW'(e));
    chk(tag, "R8 error flag", DW'(err), DW'(err_exp));
    chk(tag, "R11 request hold", DW'(proto_err), 32'd0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; seed = 32'h1234abcd; err_exp = 1'b0; lat = 0;
    rst_n = 1'b0; start = 1'b0; gate_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "done", DW'(done), 32'd0);
    chk("R1", "err", DW'(err), 32'd0);
    chk("R1", "sm_req", DW'(sm_req), 32'd0);
    chk("R1", "lm_we", DW'(lm_we), 32'd0);

    run_case("R3", 3, 3, 4, 10, 1000, 0, 1'b0, 1'b0);
    for (int n = 0; n <= K + 1; n++) begin
      lat = n % 3;
      run_case("R7 input sweep", n, 2, 3, 25, 1000, 0, 1'b0, 1'b0);
    end
    lat = 1;
    run_case("R7 input all-ones", -1, 2, 3, 25, 1000, 0, 1'b0, 1'b0);
    for (int n = 0; n <= K + 1; n++) begin
      lat = (n + 1) % 3;
      run_case("R7 output sweep", 2, n, 5, 40, 1000, 0, 1'b0, 1'b0);
    end
    lat = 2;
    run_case("R7 output all-ones", 2, -1, 5, 40, 1000, 0, 1'b0, 1'b0);
    lat = 0;
    run_case("R5 fac 1", 2, K - 1, 1, 37, 1000, 0, 1'b0, 1'b0);
    run_case("R5 fac 2", 2, K - 1, 2, -37, 1000, 0, 1'b0, 1'b0);
    run_case("R5 fac 3", 2, K - 1, 3, 53, 1000, 0, 1'b0, 1'b0);
    run_case("R5 fac -1", 2, K - 1, -1, 29, 1000, 0, 1'b0, 1'b0);
    run_case("R5 fac -5", 2, K - 1, -5, -61, 1000, 0, 1'b0, 1'b0);
    run_case("R5 fac 7", 2, K - 1, 7, 99, 1000, 0, 1'b0, 1'b0);
    run_case("R4 ceiling", 3, 3, 2, 500, 20, 0, 1'b0, 1'b0);
    run_case("R4 negative ceiling", 3, 3, 2, 10, -30, 0, 1'b0, 1'b0);
    lat = 1;
    run_case("R9 exit below floor", 3, 3, 2, 10, 1000, 1000, 1'b1, 1'b0);
    run_case("R9 run above floor", 3, 3, 2, 10, 1000, -1000, 1'b1, 1'b0);
    run_case("R9 gate off", 3, 3, 2, 10, 1000, 1000, 1'b0, 1'b0);
    run_case("R10 start while busy", 2, 2, 3, 15, 1000, 0, 1'b0, 1'b1);
    run_case("R8 zero fac no outputs", 2, 0, 0, 15, 1000, 0, 1'b0, 1'b0);
    run_case("R8 zero fac", 2, 3, 0, 15, 1000, 0, 1'b0, 1'b0);
    run_case("R8 sticky", 2, 2, 3, 15, 1000, 0, 1'b0, 1'b0);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

endmodule